// File: doc/BRIEF.md
# Nonvolatile Store Sequencer

This block sits behind the serial front end of a dual digitally controlled potentiometer. It owns the per-pot wiper position registers and the banks of nonvolatile setting registers. It applies the decoded commands that the front end hands it, one complete command per beat. Commands that only touch the wiper take effect on the next clock edge. Commands that would change a nonvolatile register are only recorded while chip select is low. The timed store starts on the clock edge that sees chip select go high again, and only if the write-protect input is high at that moment.

During the store a write-in-progress flag stays high for a programmable number of clock cycles. The nonvolatile registers take their new contents on the edge that ends the store. While the flag is up, further store commands are dropped. Reads, wiper loads and the status read still work. The command interface is a plain valid strobe with no ready. Every beat presented while chip select is low is consumed in the cycle it appears, and the block never applies back-pressure. Beats presented while chip select is high are discarded. Each read command returns a single-cycle `rd_valid` pulse, and the consumer cannot stall it.

Top module: `nvstore_seq`

## Requirements
- R1: After reset `wip_o` and `rd_valid` are 0, and every wiper position and every nonvolatile register holds `INIT` (0 by default).
- R2: Opcode 0xA (load wiper) writes `cmd_data` into the wiper of pot `cmd_pot`. The value appears on `tap_o` bits [p*W +: W] one clock after the beat. It never raises `wip_o`.
- R3: Opcode 0xD copies register `cmd_reg` of pot `cmd_pot` into that pot's wiper. Opcode 0x1 does the same for every pot at once. Both take effect one clock after the beat and never raise `wip_o`.
- R4: Opcode 0xC (write register `cmd_reg` of pot `cmd_pot` with `cmd_data`) changes nothing while chip select stays low. `wip_o` rises in the clock after the edge that samples `cs_n` going from 0 to 1.
- R5: `wip_o` stays high for exactly `STORE_CYCLES` clocks. Opcode 0x5 (status read) returns a word whose bit 0 is the busy state during the command cycle, with all other bits 0.
- R6: A nonvolatile register keeps its old value for the whole busy period. It reads back the new value once `wip_o` has fallen.
- R7: When `wp_n` is low at the chip-select rising edge, no store starts and no register changes. The level sampled at that edge governs the whole store, so later changes of `wp_n` have no effect.
- R8: While `wip_o` is high, opcodes 0xC, 0xE and 0x8 are discarded and leave no pending store. Reads, status reads and wiper loads still take effect.
- R9: Opcode 0x8 stores the wiper of every pot into register `cmd_reg` of the same pot, all within one busy period.
- R10: A frame that closes with no completed store command starts nothing. A command beat given while `cs_n` is high has no effect.
- R11: Opcode 0xE copies the wiper of pot `cmd_pot`, as it is when the beat is accepted, into register `cmd_reg` of that pot only.
- R12: Opcodes 0x9 (read wiper), 0xB (read register) and 0x5 raise `rd_valid` for one clock after the beat, with the data on `rd_data`. No other beat raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select level from the front end, synchronous, active low |
| wp_n | input | 1 | Write protect, low blocks stores |
| cmd_valid | input | 1 | One complete decoded command this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_pot | input | PW | Pot index |
| cmd_reg | input | RW | Nonvolatile register index |
| cmd_data | input | W | Data word for writes and wiper loads |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | W | Read data |
| wip_o | output | 1 | Store in progress |
| tap_o | output | POTS*W | Wiper positions, pot p at [p*W +: W] |

## Verification
A wrong busy counter shows at once as a `wip_o` pulse of the wrong length, or as a store that starts without a chip-select rise. The bench checks both on every store. A wrong pending record stays hidden until the store ends, and then shows as a wrong value on the next register read. The bench therefore reads registers back both during the busy period and after it. A wrong wiper update shows on `tap_o` one clock after the beat.

// File: rtl/nvstore_pkg.sv
`timescale 1ns/1ps
package nvstore_pkg;
  // Operation codes; the front end decodes these from the instruction nibble.
  typedef enum logic [3:0] {
    OP_GXFR_D2W = 4'h1,
    OP_RD_STAT  = 4'h5,
    OP_GXFR_W2D = 4'h8,
    OP_RD_WCR   = 4'h9,
    OP_WR_WCR   = 4'hA,
    OP_RD_DR    = 4'hB,
    OP_WR_DR    = 4'hC,
    OP_XFR_D2W  = 4'hD,
    OP_XFR_W2D  = 4'hE
  } op_e;

  typedef enum logic [1:0] {SRC_STAT = 2'd0, SRC_WCR = 2'd1, SRC_DR = 2'd2} src_e;

  typedef struct packed {
    logic nv_store;  // records a pending nonvolatile store
    logic snap;      // store data is taken from the wiper
    logic global;    // applies to every pot
    logic vol_load;  // loads a wiper right away
    logic vol_dr;    // wiper load source is a nonvolatile register
    logic rd;        // returns a read word
    src_e rd_src;
  } cls_t;
endpackage

// File: rtl/nvstore_decode.sv
`timescale 1ns/1ps
module nvstore_decode
  import nvstore_pkg::*;
(
  input  logic [3:0] op,
  output cls_t       cls
);
  always_comb begin
    cls = '0;
    case (op)
      OP_WR_DR:    cls.nv_store = 1'b1;
      OP_XFR_W2D:  begin cls.nv_store = 1'b1; cls.snap = 1'b1; end
      OP_GXFR_W2D: begin cls.nv_store = 1'b1; cls.snap = 1'b1; cls.global = 1'b1; end
      OP_WR_WCR:   cls.vol_load = 1'b1;
      OP_XFR_D2W:  begin cls.vol_load = 1'b1; cls.vol_dr = 1'b1; end
      OP_GXFR_D2W: begin cls.vol_load = 1'b1; cls.vol_dr = 1'b1; cls.global = 1'b1; end
      OP_RD_WCR:   begin cls.rd = 1'b1; cls.rd_src = SRC_WCR; end
      OP_RD_DR:    begin cls.rd = 1'b1; cls.rd_src = SRC_DR; end
      OP_RD_STAT:  begin cls.rd = 1'b1; cls.rd_src = SRC_STAT; end
      default:     cls = '0;
    endcase
  end
endmodule

// File: rtl/nvstore_timer.sv
`timescale 1ns/1ps
module nvstore_timer #(
  parameter int unsigned CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/nvstore_bank.sv
`timescale 1ns/1ps
module nvstore_bank #(
  parameter int unsigned POTS = 2,
  parameter int unsigned REGS = 4,
  parameter int unsigned W    = 6,
  parameter int unsigned INIT = 0,
  localparam int unsigned RW  = $clog2(REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [POTS-1:0]          wcr_we,
  input  logic [POTS-1:0][W-1:0]   wcr_wd,
  input  logic [POTS-1:0]          dr_we,
  input  logic [RW-1:0]            dr_wsel,
  input  logic [POTS-1:0][W-1:0]   dr_wd,
  input  logic [RW-1:0]            dr_rsel,
  output logic [POTS-1:0][W-1:0]   dr_col,
  output logic [POTS-1:0][W-1:0]   wcr_q
);
  for (genvar p = 0; p < POTS; p++) begin : g_pot
    logic [REGS-1:0][W-1:0] cells;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < REGS; r++) cells[r] <= W'(INIT);
      end else if (dr_we[p]) begin
        cells[dr_wsel] <= dr_wd[p];
      end
    end

    // The wiper comes up at the value of register 0.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wcr_q[p] <= W'(INIT);
      else if (wcr_we[p]) wcr_q[p] <= wcr_wd[p];
    end

    assign dr_col[p] = cells[dr_rsel];
  end
endmodule

// File: rtl/nvstore_seq.sv
`timescale 1ns/1ps
module nvstore_seq
  import nvstore_pkg::*;
#(
  parameter int unsigned POTS         = 2,
  parameter int unsigned REGS         = 4,
  parameter int unsigned W            = 6,
  parameter int unsigned STORE_CYCLES = 500000,
  parameter int unsigned INIT         = 0,
  localparam int unsigned PW          = (POTS < 2) ? 1 : $clog2(POTS),
  localparam int unsigned RW          = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wp_n,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [PW-1:0]   cmd_pot,
  input  logic [RW-1:0]   cmd_reg,
  input  logic [W-1:0]    cmd_data,
  output logic            rd_valid,
  output logic [W-1:0]    rd_data,
  output logic            wip_o,
  output logic [POTS*W-1:0] tap_o
);
  cls_t cls;
  nvstore_decode u_dec (.op(cmd_op), .cls(cls));

  // Frame edge detection on the synchronous select level.
  logic cs_q, cs_rise, acc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end
  assign cs_rise = cs_n && !cs_q;
  assign acc     = cmd_valid && !cs_n;

  // Store timer.
  logic busy, done, start;
  nvstore_timer #(.CYCLES(STORE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  // Register bank.
  logic [POTS-1:0]        wcr_we, dr_we;
  logic [POTS-1:0][W-1:0] wcr_wd, dr_col, wcr_q;
  logic [POTS-1:0][W-1:0] pend_data;
  logic [RW-1:0]          pend_reg;
  logic [PW-1:0]          pend_pot;
  logic                   pend_v, pend_glob;

  nvstore_bank #(.POTS(POTS), .REGS(REGS), .W(W), .INIT(INIT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wcr_we(wcr_we), .wcr_wd(wcr_wd),
    .dr_we(dr_we), .dr_wsel(pend_reg), .dr_wd(pend_data),
    .dr_rsel(cmd_reg), .dr_col(dr_col), .wcr_q(wcr_q)
  );

  // Pending store record: armed inside a frame, consumed at the frame end.
  logic nv_ok, vol_ok;
  assign nv_ok  = acc && cls.nv_store && !busy;
  assign vol_ok = acc && cls.vol_load;
  assign start  = cs_rise && pend_v && wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_glob <= 1'b0;
      pend_pot  <= '0;
      pend_reg  <= '0;
      pend_data <= '0;
    end else if (cs_rise) begin
      pend_v <= 1'b0;
    end else if (nv_ok) begin
      pend_v    <= 1'b1;
      pend_glob <= cls.global;
      pend_pot  <= cmd_pot;
      pend_reg  <= cmd_reg;
      for (int p = 0; p < POTS; p++)
        pend_data[p] <= cls.snap ? wcr_q[p] : cmd_data;
    end
  end

  for (genvar p = 0; p < POTS; p++) begin : g_sel
    assign wcr_we[p] = vol_ok && (cls.global || cmd_pot == PW'(p));
    assign wcr_wd[p] = cls.vol_dr ? dr_col[p] : cmd_data;
    assign dr_we[p]  = done && (pend_glob || pend_pot == PW'(p));
  end

  // Read return path.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc && cls.rd;
      if (acc && cls.rd) begin
        case (cls.rd_src)
          SRC_WCR: rd_data <= wcr_q[cmd_pot];
          SRC_DR:  rd_data <= dr_col[cmd_pot];
          default: rd_data <= {{(W-1){1'b0}}, busy};
        endcase
      end
    end
  end

  assign wip_o = busy;
  assign tap_o = wcr_q;
endmodule

// File: rtl/nvstore_seq_checks.sv
`timescale 1ns/1ps
module nvstore_seq_checks #(
  parameter int unsigned W            = 6,
  parameter int unsigned STORE_CYCLES = 500000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         wp_n,
  input logic         cmd_valid,
  input logic [3:0]   cmd_op,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic         wip_o
);
  logic [31:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run <= '0;
    else if (wip_o) run <= run + 1'b1;
    else            run <= '0;
  end

  logic is_rd;
  assign is_rd = cmd_valid && !cs_n &&
                 (cmd_op == 4'h9 || cmd_op == 4'hB || cmd_op == 4'h5);

  p_wip_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> ($past(cs_n, 1) && !$past(cs_n, 2)));

  p_wip_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_o) |-> (run == 32'(STORE_CYCLES)));

  p_status_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cs_n && cmd_op == 4'h5) |=>
      (rd_valid && rd_data == {{(W-1){1'b0}}, $past(wip_o)}));

  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n) && !wp_n && !wip_o) |=> !wip_o);

  p_rd_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_valid);

  p_no_stray_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rd_valid);
endmodule

bind nvstore_seq nvstore_seq_checks #(.W(W), .STORE_CYCLES(STORE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .rd_valid(rd_valid), .rd_data(rd_data), .wip_o(wip_o)
);

// File: tb/nvstore_seq_bench.sv
`timescale 1ns/1ps
module nvstore_seq_bench;
  import nvstore_pkg::*;

  localparam int POTS = 2;
  localparam int REGS = 4;
  localparam int W    = 6;
  localparam int N    = 12;
  localparam int PW   = 1;
  localparam int RW   = 2;

  logic clk = 1'b0;
  logic rst_n, cs_n, wp_n, cmd_valid;
  logic [3:0] cmd_op;
  logic [PW-1:0] cmd_pot;
  logic [RW-1:0] cmd_reg;
  logic [W-1:0] cmd_data;
  logic rd_valid, wip_o;
  logic [W-1:0] rd_data;
  logic [POTS*W-1:0] tap_o;

  always #10 clk = ~clk;

  nvstore_seq #(.POTS(POTS), .REGS(REGS), .W(W), .STORE_CYCLES(N)) u_nvstore_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .wip_o(wip_o), .tap_o(tap_o)
  );

  int checks = 0;
  int errors = 0;
  int exp_dr [POTS][REGS];
  int exp_tap [POTS];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int tap(input int p);
    return int'((tap_o >> (p * W)) & {W{1'b1}});
  endfunction

  task automatic send(input logic [3:0] op, input int p, input int r, input int d);
    cmd_op = op; cmd_pot = PW'(p); cmd_reg = RW'(r); cmd_data = W'(d);
    cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic open_f();
    cs_n = 1'b0; tick();
  endtask

  task automatic close_f();
    cs_n = 1'b1; tick();
  endtask

  task automatic count_busy(output int run);
    run = 0;
    while (wip_o && run < 1000) begin run++; tick(); end
  endtask

  task automatic store(input logic [3:0] op, input int p, input int r, input int d,
                       output int run);
    open_f(); send(op, p, r, d); close_f(); count_busy(run);
  endtask

  task automatic rd_dr(input int p, input int r, output int v);
    open_f(); send(OP_RD_DR, p, r, 0); v = int'(rd_data); close_f();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, run;
    rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1; cmd_valid = 1'b0;
    cmd_op = '0; cmd_pot = '0; cmd_reg = '0; cmd_data = '0;
    for (int p = 0; p < POTS; p++) begin
      exp_tap[p] = 0;
      for (int r = 0; r < REGS; r++) exp_dr[p][r] = 0;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    check("R1 wip", int'(wip_o), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 taps", int'(tap_o), 0);
    for (int p = 0; p < POTS; p++)
      for (int r = 0; r < REGS; r++) begin
        rd_dr(p, r, v); check("R1 register", v, 0);
      end

    // R2: wiper loads, swept values
    for (int p = 0; p < POTS; p++)
      for (int k = 0; k < 4; k++) begin
        int d = (p * 29 + k * 21 + 7) % 64;
        open_f(); send(OP_WR_WCR, p, 0, d);
        check("R2 tap", tap(p), d);
        check("R12 no rd_valid after load", int'(rd_valid), 0);
        close_f(); exp_tap[p] = d;
        check("R2 no wip", int'(wip_o), 0);
        open_f(); send(OP_RD_WCR, p, 0, 0);
        check("R12 rd_valid", int'(rd_valid), 1);
        check("R12 wiper read", int'(rd_data), d);
        close_f();
      end

    // R4/R5/R6: store sweep over every register of every pot
    for (int p = 0; p < POTS; p++)
      for (int r = 0; r < REGS; r++) begin
        int d = (p * 23 + r * 11 + 5) % 64;
        open_f(); send(OP_WR_DR, p, r, d);
        send(OP_RD_DR, p, r, 0);
        check("R4 unchanged before frame end", int'(rd_data), exp_dr[p][r]);
        check("R4 no wip inside frame", int'(wip_o), 0);
        close_f();
        check("R4 wip after rise", int'(wip_o), 1);
        count_busy(run);
        check("R5 busy length", run, N);
        exp_dr[p][r] = d;
        rd_dr(p, r, v); check("R6 new value", v, d);
      end

    // R8/R5/R6: activity during the busy period
    begin
      int x = 45;
      open_f(); send(OP_WR_DR, 0, 0, x); close_f();
      open_f();
      send(OP_RD_DR, 0, 0, 0);
      check("R6 old value while busy", int'(rd_data), exp_dr[0][0]);
      send(OP_RD_STAT, 0, 0, 0);
      check("R5 status busy", int'(rd_data), 1);
      send(OP_WR_DR, 1, 3, 19);
      send(OP_WR_WCR, 1, 0, 9);
      check("R8 wiper load while busy", tap(1), 9);
      exp_tap[1] = 9;
      close_f();
      count_busy(run);
      exp_dr[0][0] = x;
      repeat (3) begin tick(); check("R8 no second store", int'(wip_o), 0); end
      rd_dr(0, 0, v); check("R6 committed", v, x);
      rd_dr(1, 3, v); check("R8 rejected store", v, exp_dr[1][3]);
      open_f(); send(OP_RD_STAT, 0, 0, 0);
      check("R5 status idle", int'(rd_data), 0);
      close_f();
    end

    // R7: write protect low at the rising edge
    open_f(); send(OP_WR_DR, 1, 1, 33); wp_n = 1'b0; close_f();
    check("R7 blocked wip", int'(wip_o), 0);
    repeat (2) begin tick(); check("R7 still idle", int'(wip_o), 0); end
    wp_n = 1'b1;
    rd_dr(1, 1, v); check("R7 register kept", v, exp_dr[1][1]);
    // R7: protect falls after the edge; store still completes
    open_f(); send(OP_WR_DR, 1, 1, 34); close_f();
    wp_n = 1'b0;
    count_busy(run);
    check("R7 sampled level holds", run, N);
    wp_n = 1'b1; exp_dr[1][1] = 34;
    rd_dr(1, 1, v); check("R7 committed", v, 34);

    // R9: global wiper-to-register store
    open_f(); send(OP_WR_WCR, 0, 0, 50); send(OP_WR_WCR, 1, 0, 13); close_f();
    exp_tap[0] = 50; exp_tap[1] = 13;
    store(OP_GXFR_W2D, 0, 2, 0, run);
    check("R9 single busy period", run, N);
    exp_dr[0][2] = 50; exp_dr[1][2] = 13;
    rd_dr(0, 2, v); check("R9 pot0", v, 50);
    rd_dr(1, 2, v); check("R9 pot1", v, 13);

    // R11: single-pot wiper-to-register store
    store(OP_XFR_W2D, 1, 1, 0, run);
    check("R11 busy length", run, N);
    exp_dr[1][1] = 13;
    rd_dr(1, 1, v); check("R11 selected pot", v, 13);
    rd_dr(0, 1, v); check("R11 other pot", v, exp_dr[0][1]);

    // R3: register-to-wiper transfers
    open_f(); send(OP_XFR_D2W, 0, 3, 0);
    check("R3 single tap0", tap(0), exp_dr[0][3]);
    check("R3 single tap1", tap(1), exp_tap[1]);
    send(OP_GXFR_D2W, 0, 1, 0);
    check("R3 global tap0", tap(0), exp_dr[0][1]);
    check("R3 global tap1", tap(1), exp_dr[1][1]);
    close_f();
    check("R3 no wip", int'(wip_o), 0);
    exp_tap[0] = exp_dr[0][1]; exp_tap[1] = exp_dr[1][1];

    // R10: empty frame and beats outside a frame
    open_f(); close_f();
    check("R10 empty frame", int'(wip_o), 0);
    send(OP_WR_DR, 0, 1, 61);
    send(OP_WR_WCR, 0, 0, 61);
    check("R10 load outside frame", tap(0), exp_tap[0]);
    send(OP_RD_STAT, 0, 0, 0);
    check("R10 read outside frame", int'(rd_valid), 0);
    open_f(); close_f();
    check("R10 no store", int'(wip_o), 0);
    rd_dr(0, 1, v); check("R10 register kept", v, exp_dr[0][1]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule